// File: doc/BRIEF.md
# Processor Status Word and Stack Select Unit

This unit holds a processor's 11-bit status word and its two 16-bit stack pointers. It takes condition results from an arithmetic unit and updates only the flags that a per-flag mask enables. A full-word write port lets software replace the status word. The low eight bits are live, and the top three bits always read as zero.

The unit also keeps interrupt and debug state consistent. An interrupt acknowledge clears the debug and interrupt-enable flags. In the cycle after the acknowledge, the unit presents the status word as it stood before the acknowledge, so the surrounding logic can push it. While the debug flag is set, each retired instruction raises a single-step request for one cycle. Flag bit 7 chooses which stack pointer is live. That pointer is the only one that load, increment and decrement operations reach, and it is the one shown on the stack pointer output.

Top module: `psw_unit`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, and after it is released, all flags, both stack pointers, step_req and saved_valid are 0.
- R2: When alu_upd is 1, the flags change in the next cycle. Each flag changes only if its alu_mask bit is set: bit 0 (carry) takes alu_carry, bit 2 (zero) is 1 exactly when alu_result is 0, bit 3 (sign) takes the MSB of alu_result, and bit 5 (overflow) takes alu_ovf. The mask bits are alu_mask[0] for carry, [1] for zero, [2] for sign and [3] for overflow. Flags whose mask bit is clear keep their value.
- R3: When wr_en is 1, the flags take wr_data[7:0] in the next cycle. This write takes priority over an ALU update in the same cycle.
- R4: flags[10:8] always read as 0, whatever value wr_data carries.
- R5: When irq_ack is 1, flag bit 1 (debug) and flag bit 6 (interrupt enable) are 0 in the next cycle. This holds even when a write in the same cycle sets them.
- R6: In the cycle after irq_ack, saved_valid is 1 and saved_flags equals the flag word as it was in the acknowledge cycle. At all other times, saved_valid is 0.
- R7: step_req is 1 in the cycle after a cycle in which retire is 1 and the debug flag (bit 1) is 1. Otherwise step_req is 0.
- R8: bank_sel follows flag bit 4 and int_en follows flag bit 6.
- R9: sp_active shows the user pointer when flag bit 7 is 0 and the interrupt pointer when flag bit 7 is 1.
- R10: Stack operations act only on the pointer selected by the current flag bit 7. sp_ld loads sp_ld_val. Otherwise sp_inc adds SP_STEP (default 2). Otherwise sp_dec subtracts SP_STEP. The other pointer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_upd | input | 1 | Apply ALU condition results |
| alu_mask | input | 4 | Per-flag enable: [0] carry, [1] zero, [2] sign, [3] overflow |
| alu_carry | input | 1 | Carry, borrow or shift-out bit |
| alu_ovf | input | 1 | Arithmetic overflow |
| alu_result | input | DW | ALU result used for the zero and sign flags |
| wr_en | input | 1 | Full status word write |
| wr_data | input | 11 | Value for the full write |
| retire | input | 1 | Instruction retired strobe |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| sp_ld | input | 1 | Load the active stack pointer |
| sp_ld_val | input | SPW | Value for the stack pointer load |
| sp_inc | input | 1 | Increment the active stack pointer |
| sp_dec | input | 1 | Decrement the active stack pointer |
| flags | output | 11 | Status word |
| sp_active | output | SPW | Selected stack pointer |
| bank_sel | output | 1 | Register bank select |
| int_en | output | 1 | Maskable interrupt enable |
| step_req | output | 1 | Single-step interrupt request |
| saved_flags | output | 11 | Status word captured at acknowledge |
| saved_valid | output | 1 | saved_flags is valid |

## Verification
The assertions check, on every cycle, that the reserved bits are zero and that an acknowledge clears the debug and enable flags. They also check that saved_flags carries the word from the acknowledge cycle, that the step request follows retire exactly when the debug flag is set, and that a write wins over an ALU update. Finally, they check that the active pointer holds still when nothing can move it. Only the bench scenarios can show the per-flag arithmetic of masked ALU updates and the correct pointer receiving an operation. The bench also shows that the unselected pointer keeps its value across a switch of the select flag, and that a write and an acknowledge in the same cycle combine correctly.

// File: rtl/psw_unit.sv
module psw_unit #(
  parameter int DW      = 16,
  parameter int SPW     = 16,
  parameter int SP_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alu_upd,
  input  logic [3:0]       alu_mask,
  input  logic             alu_carry,
  input  logic             alu_ovf,
  input  logic [DW-1:0]    alu_result,
  input  logic             wr_en,
  input  logic [10:0]      wr_data,
  input  logic             retire,
  input  logic             irq_ack,
  input  logic             sp_ld,
  input  logic [SPW-1:0]   sp_ld_val,
  input  logic             sp_inc,
  input  logic             sp_dec,
  output logic [10:0]      flags,
  output logic [SPW-1:0]   sp_active,
  output logic             bank_sel,
  output logic             int_en,
  output logic             step_req,
  output logic [10:0]      saved_flags,
  output logic             saved_valid
);

  localparam int BC = 0, BD = 1, BZ = 2, BS = 3, BB = 4, BO = 5, BI = 6, BU = 7;
  localparam logic [SPW-1:0] STEP = SPW'(SP_STEP);

  logic [7:0]     live, live_nx;
  logic [SPW-1:0] usp, isp, sp_nx;
  logic           sel_isp;

  assign flags     = {3'b000, live};
  assign bank_sel  = live[BB];
  assign int_en    = live[BI];
  assign sel_isp   = live[BU];
  assign sp_active = sel_isp ? isp : usp;

  // R2 R3 R5: write beats ALU update, acknowledge clears D and I last
  always_comb begin
    live_nx = live;
    if (wr_en) begin
      live_nx = wr_data[7:0];
    end else if (alu_upd) begin
      if (alu_mask[0]) live_nx[BC] = alu_carry;
      if (alu_mask[1]) live_nx[BZ] = (alu_result == '0);
      if (alu_mask[2]) live_nx[BS] = alu_result[DW-1];
      if (alu_mask[3]) live_nx[BO] = alu_ovf;
    end
    if (irq_ack) begin
      live_nx[BD] = 1'b0;
      live_nx[BI] = 1'b0;
    end
  end

  // R10: load > increment > decrement on the active pointer
  always_comb begin
    if (sp_ld)       sp_nx = sp_ld_val;
    else if (sp_inc) sp_nx = sp_active + STEP;
    else if (sp_dec) sp_nx = sp_active - STEP;
    else             sp_nx = sp_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live        <= '0;
      usp         <= '0;
      isp         <= '0;
      step_req    <= 1'b0;
      saved_flags <= '0;
      saved_valid <= 1'b0;
    end else begin
      live        <= live_nx;
      step_req    <= retire & live[BD];
      saved_valid <= irq_ack;
      if (irq_ack) saved_flags <= flags;
      if (sel_isp) isp <= sp_nx;
      else         usp <= sp_nx;
    end
  end

endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk #(
  parameter int SPW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            alu_upd,
  input logic            wr_en,
  input logic [10:0]     wr_data,
  input logic            retire,
  input logic            irq_ack,
  input logic            sp_ld,
  input logic            sp_inc,
  input logic            sp_dec,
  input logic [10:0]     flags,
  input logic [SPW-1:0]  sp_active,
  input logic            step_req,
  input logic [10:0]     saved_flags,
  input logic            saved_valid
);

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flags[10:8] == 3'b000);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (flags[1] == 1'b0 && flags[6] == 1'b0));

  a_r6_saved_word: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (saved_valid && saved_flags == $past(flags)));

  a_r6_saved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ack |=> !saved_valid);

  a_r7_step_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && flags[1]) |=> step_req);

  a_r7_step_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire && flags[1]) |=> !step_req);

  a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !irq_ack) |=> flags == {3'b000, $past(wr_data[7:0])});

  a_r10_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_ld && !sp_inc && !sp_dec && !wr_en) |=> $stable(sp_active));

endmodule

bind psw_unit psw_unit_chk #(.SPW(SPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alu_upd(alu_upd), .wr_en(wr_en), .wr_data(wr_data),
  .retire(retire), .irq_ack(irq_ack), .sp_ld(sp_ld), .sp_inc(sp_inc), .sp_dec(sp_dec),
  .flags(flags), .sp_active(sp_active), .step_req(step_req),
  .saved_flags(saved_flags), .saved_valid(saved_valid)
);

// File: tb/sim_psw_unit.sv
module sim_psw_unit;
  localparam int DW = 16, SPW = 16, STEP = 2;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic alu_upd = 0, alu_carry = 0, alu_ovf = 0, wr_en = 0, retire = 0, irq_ack = 0;
  logic sp_ld = 0, sp_inc = 0, sp_dec = 0;
  logic [3:0] alu_mask = 0;
  logic [DW-1:0] alu_result = 0;
  logic [10:0] wr_data = 0;
  logic [SPW-1:0] sp_ld_val = 0;
  logic [10:0] flags, saved_flags;
  logic [SPW-1:0] sp_active;
  logic bank_sel, int_en, step_req, saved_valid;

  psw_unit #(.DW(DW), .SPW(SPW), .SP_STEP(STEP)) u0 (.*);

  int checks = 0, fails = 0;
  logic [10:0] mf = 0, msaved = 0;
  logic [SPW-1:0] musp = 0, misp = 0;
  logic mstep = 0, msv = 0;

  function automatic logic [10:0] next_flags(logic [10:0] f);
    logic [10:0] n = f;
    if (wr_en) n = {3'b000, wr_data[7:0]};
    else if (alu_upd) begin
      if (alu_mask[0]) n[0] = alu_carry;
      if (alu_mask[1]) n[2] = (alu_result == 0);
      if (alu_mask[2]) n[3] = alu_result[DW-1];
      if (alu_mask[3]) n[5] = alu_ovf;
    end
    if (irq_ack) begin n[1] = 0; n[6] = 0; end
    return n;
  endfunction

  function automatic logic [SPW-1:0] next_sp(logic [SPW-1:0] v);
    if (sp_ld) return sp_ld_val;
    if (sp_inc) return v + SPW'(STEP);
    if (sp_dec) return v - SPW'(STEP);
    return v;
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    cmp(tag, "flags R2/R3/R4/R5", 32'(flags), 32'(mf));
    cmp(tag, "sp_active R9/R10", 32'(sp_active), 32'(mf[7] ? misp : musp));
    cmp(tag, "bank_sel/int_en R8", {30'd0, bank_sel, int_en}, {30'd0, mf[4], mf[6]});
    cmp(tag, "step_req R7", 32'(step_req), 32'(mstep));
    cmp(tag, "saved_valid R6", 32'(saved_valid), 32'(msv));
    if (msv) cmp(tag, "saved_flags R6", 32'(saved_flags), 32'(msaved));
  endtask

  task automatic tick(string tag);
    logic [10:0] nf = next_flags(mf);
    if (mf[7]) misp = next_sp(misp); else musp = next_sp(musp);
    mstep = retire & mf[1];
    msv = irq_ack;
    if (irq_ack) msaved = mf;
    mf = nf;
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle();
    alu_upd = 0; wr_en = 0; retire = 0; irq_ack = 0; sp_ld = 0; sp_inc = 0; sp_dec = 0;
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5813));
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    compare_all("R1 after reset");

    // R4 R8 R9: write all ones, top bits stay zero, interrupt pointer selected
    idle(); wr_en = 1; wr_data = 11'h7FF; tick("R4");
    // R3: write beats simultaneous ALU update
    idle(); wr_en = 1; wr_data = 11'h000; alu_upd = 1; alu_mask = 4'hF;
    alu_carry = 1; alu_ovf = 1; alu_result = 16'h8000; tick("R3");
    // R2: masked update, only carry and sign
    idle(); alu_upd = 1; alu_mask = 4'b0101; alu_carry = 1; alu_ovf = 1; alu_result = 16'h0000; tick("R2");
    // R2: zero flag from zero result
    idle(); alu_upd = 1; alu_mask = 4'b0010; alu_result = 16'h0000; tick("R2");
    // R5 R6: set D and I, then ack with a write that sets them again
    idle(); wr_en = 1; wr_data = 11'h042; tick("R5 setup");
    idle(); wr_en = 1; wr_data = 11'h0FF; irq_ack = 1; tick("R5");
    idle(); tick("R6 pulse end");
    // R7: debug set, retire raises step
    idle(); wr_en = 1; wr_data = 11'h002; tick("R7 setup");
    idle(); retire = 1; tick("R7");
    idle(); tick("R7 drop");
    // R10: user pointer ops, interrupt pointer untouched
    idle(); sp_ld = 1; sp_ld_val = 16'h1000; tick("R10 load");
    idle(); sp_inc = 1; sp_dec = 1; tick("R10 inc wins");
    idle(); wr_en = 1; wr_data = 11'h080; tick("R9 switch");
    idle(); sp_dec = 1; tick("R10 isp wrap");
    idle(); wr_en = 1; wr_data = 11'h000; tick("R10 usp kept");

    for (int i = 0; i < 4000; i++) begin
      alu_upd = ($urandom % 2) == 0;
      alu_mask = 4'($urandom);
      alu_carry = 1'($urandom);
      alu_ovf = 1'($urandom);
      alu_result = ($urandom % 4 == 0) ? '0 : DW'($urandom);
      wr_en = ($urandom % 8) == 0;
      wr_data = 11'($urandom);
      retire = 1'($urandom);
      irq_ack = ($urandom % 6) == 0;
      sp_ld = ($urandom % 8) == 0;
      sp_ld_val = SPW'($urandom);
      sp_inc = ($urandom % 4) == 0;
      sp_dec = ($urandom % 4) == 0;
      tick("RND");
    end

    // R1: reset mid-run clears everything
    idle(); rst_n = 0;
    mf = 0; musp = 0; misp = 0; mstep = 0; msv = 0;
    @(negedge clk);
    compare_all("R1 re-reset");
    rst_n = 1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule